// File: doc/BRIEF.md
# Four-Tap Qualified FIR Filter

This block is a direct-form finite impulse response filter with four taps over unsigned 4-bit samples. The tap weights are fixed at 1, 3, 2 and 1, applied from the newest sample to the oldest. Each sample is presented together with a valid strobe. Only strobed samples are accepted into the three-deep history. The weighted sum passes through one output register before it reaches the output port.

A fill tracker shows how many history stages hold real samples. It is a state machine with the states FILL_EMPTY, FILL_ONE, FILL_TWO and FILL_FULL. Each accepted sample moves it one step: EMPTY→ONE, ONE→TWO, TWO→FULL. FULL→FULL is a self-loop, and any other state also holds when no sample is accepted. Reset sends every state back to FILL_EMPTY. Each history stage also carries its own valid bit, which shifts with the data.

The output is flagged valid only when the sum was built entirely from real input samples. Values that come from reset contents are never flagged valid. When no sample is strobed, the history and the output sum hold their values.

Top module: `qual_fir4`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `out_sum` to 0, clears `out_valid` to 0, and empties the sample history. After that edge both outputs read 0.
- R2: At each edge where `in_valid` is high, `out_sum` loads x[n] + 3·x[n-1] + 2·x[n-2] + x[n-3]. Here x[n] is the sample presented at that edge and x[n-1..n-3] are the earlier accepted samples. History stages not yet filled since reset count as 0.
- R3: `out_valid` stays low through the first three accepted samples after reset. It rises at the edge that accepts the fourth.
- R4: Once the history is full, `out_valid` is high after every edge at which `in_valid` is high.
- R5: After an edge where `in_valid` is low, `out_valid` is 0 and `out_sum` keeps its previous value.
- R6: Cycles with `in_valid` low are skipped by the history. The next accepted sample combines with the samples accepted before the gap. A gap neither clears the fill state nor lets the sum go out unflagged.
- R7: A reset in the middle of a stream restarts the fill. Four new accepted samples are needed before `out_valid` rises again, and the old samples contribute nothing.
- R8: `out_sum` is 10 bits wide and never wraps. Its largest value, 105, occurs when four samples of 15 are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sample | input | 4 | Unsigned input sample |
| in_valid | input | 1 | High when `in_sample` holds a sample to accept |
| out_sum | output | 10 | Registered weighted sum |
| out_valid | output | 1 | High when `out_sum` comes only from real samples |

## Verification
A long, unbroken stream of mixed values sweeps every weight against many sample combinations. It shows whether each tap carries its own weight and whether the taps sit in the right order. A stream broken by scattered gaps shows whether the history holds across a bubble and whether the valid flag drops for exactly one cycle. Streams of all zeros and all fifteens mark the bottom and top of the output range. A reset placed mid-stream shows whether stale samples leak into the restarted fill and whether the flag waits for four fresh samples.

// File: rtl/qual_fir4_pkg.sv
package qual_fir4_pkg;

    localparam int unsigned TAPS = 4;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_ONE,
        FILL_TWO,
        FILL_FULL
    } fill_state_e;

    // Weight of tap idx, idx 0 being the newest sample.
    function automatic int unsigned tap_coef(input int unsigned idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned coef_total();
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < TAPS; i++) acc += tap_coef(i);
        return acc;
    endfunction

endpackage

// File: rtl/qual_fir4_history.sv
module qual_fir4_history #(
    parameter int SAMPLE_W = 4,
    parameter int DEPTH    = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             shift_en,
    input  logic [SAMPLE_W-1:0]              new_sample,
    output logic [DEPTH-1:0][SAMPLE_W-1:0]   hist,
    output logic [DEPTH-1:0]                 hist_vld
);

    logic [DEPTH-1:0][SAMPLE_W-1:0] src;
    logic [DEPTH-1:0]               src_vld;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_src
            if (g == 0) begin : g_head
                assign src[g]     = new_sample;
                assign src_vld[g] = 1'b1;
            end else begin : g_body
                assign src[g]     = hist[g-1];
                assign src_vld[g] = hist_vld[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            hist_vld <= '0;
        end else if (shift_en) begin
            hist     <= src;
            hist_vld <= src_vld;
        end
    end

endmodule

// File: rtl/qual_fir4_fill.sv
module qual_fir4_fill
    import qual_fir4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic hist_full
);

    fill_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FILL_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: if (accept) state_d = FILL_ONE;
            FILL_ONE:   if (accept) state_d = FILL_TWO;
            FILL_TWO:   if (accept) state_d = FILL_FULL;
            FILL_FULL:  state_d = FILL_FULL;
        endcase
    end

    always_comb begin
        hist_full = (state_q == FILL_FULL);
    end

endmodule

// File: rtl/qual_fir4_mac.sv
module qual_fir4_mac
    import qual_fir4_pkg::*;
#(
    parameter int SAMPLE_W = 4,
    parameter int DEPTH    = 3,
    parameter int PROD_W   = 8,
    parameter int OUT_W    = 10
) (
    input  logic [SAMPLE_W-1:0]            newest,
    input  logic [DEPTH-1:0][SAMPLE_W-1:0] hist,
    output logic [OUT_W-1:0]               sum
);

    logic [DEPTH:0][SAMPLE_W-1:0] taps;
    logic [DEPTH:0][PROD_W-1:0]   prod;

    assign taps = {hist, newest};

    genvar g;
    generate
        for (g = 0; g <= DEPTH; g++) begin : g_prod
            localparam logic [PROD_W-1:0] WEIGHT = PROD_W'(tap_coef(g));
            assign prod[g] = PROD_W'(taps[g]) * WEIGHT;
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int i = 0; i <= DEPTH; i++) sum = sum + OUT_W'(prod[i]);
    end

endmodule

// File: rtl/qual_fir4.sv
module qual_fir4
    import qual_fir4_pkg::*;
#(
    parameter  int SAMPLE_W = 4,
    localparam int PROD_W   = 2 * SAMPLE_W,
    localparam int OUT_W    = PROD_W + 2,
    localparam int DEPTH    = TAPS - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                in_valid,
    output logic [OUT_W-1:0]    out_sum,
    output logic                out_valid
);

    logic [DEPTH-1:0][SAMPLE_W-1:0] hist;
    logic [DEPTH-1:0]               hist_vld;
    logic                           hist_full;
    logic [OUT_W-1:0]               mac_sum;

    qual_fir4_history #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (DEPTH)
    ) u_history (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (in_valid),
        .new_sample (in_sample),
        .hist       (hist),
        .hist_vld   (hist_vld)
    );

    qual_fir4_fill u_fill (
        .clk       (clk),
        .rst       (rst),
        .accept    (in_valid),
        .hist_full (hist_full)
    );

    qual_fir4_mac #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (DEPTH),
        .PROD_W   (PROD_W),
        .OUT_W    (OUT_W)
    ) u_mac (
        .newest (in_sample),
        .hist   (hist),
        .sum    (mac_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sum   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid & hist_full;
            if (in_valid) out_sum <= mac_sum;
        end
    end

endmodule

// File: rtl/qual_fir4_checker.sv
module qual_fir4_checker
    import qual_fir4_pkg::*;
#(
    parameter int SAMPLE_W = 4,
    parameter int DEPTH    = 3,
    parameter int OUT_W    = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OUT_W-1:0] out_sum,
    input logic             out_valid,
    input logic             hist_full,
    input logic [DEPTH-1:0] hist_vld
);

    localparam int unsigned SUM_MAX = ((2 ** SAMPLE_W) - 1) * coef_total();

    // R1: reset leaves both outputs cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (out_valid == 1'b0 && out_sum == '0));

    // R5: idle cycle drops the flag and holds the sum
    assert_idle_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sum));

    // R3: flag only after the fill tracker reports a full history
    assert_flag_needs_fill_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(hist_full));

    // R6: fill tracker agrees with the per-stage valid bits
    assert_fill_agrees_R6: assert property (@(posedge clk) disable iff (rst)
        hist_full == (&hist_vld));

    // R8: output stays within range
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        32'(out_sum) <= SUM_MAX);

endmodule

bind qual_fir4 qual_fir4_checker #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH),
    .OUT_W    (OUT_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_sum   (out_sum),
    .out_valid (out_valid),
    .hist_full (hist_full),
    .hist_vld  (hist_vld)
);

// File: tb/qual_fir4_test.sv
`timescale 1ns/1ps
module qual_fir4_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_sample = '0;
    logic       in_valid = 1'b0;
    logic [9:0] out_sum;
    logic       out_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int h0, h1, h2, fill;
    int exp_sum;
    bit exp_valid;

    always #2 clk = ~clk;

    qual_fir4 uut (
        .clk       (clk),
        .rst       (rst),
        .in_sample (in_sample),
        .in_valid  (in_valid),
        .out_sum   (out_sum),
        .out_valid (out_valid)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        h0 = 0; h1 = 0; h2 = 0; fill = 0;
        exp_sum = 0; exp_valid = 0;
        check({tag, " out_valid"}, int'(out_valid), 0);
        check({tag, " out_sum"}, int'(out_sum), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int s, input bit v, input string tag);
        @(negedge clk);
        in_sample = 4'(s);
        in_valid = v;
        @(posedge clk);
        #1;
        if (v) begin
            exp_valid = (fill >= 3);
            exp_sum = s + 3 * h0 + 2 * h1 + h2;
            h2 = h1; h1 = h0; h0 = s;
            if (fill < 3) fill++;
        end else begin
            exp_valid = 0;
        end
        check({tag, " valid"}, int'(out_valid), int'(exp_valid));
        check({tag, " sum"}, int'(out_sum), exp_sum);
    endtask

    initial begin
        // R1: reset state
        do_reset("R1");

        // R3: fill sequence, flag rises on fourth sample
        step(1, 1, "R3");
        step(3, 1, "R3");
        step(2, 1, "R3");
        step(1, 1, "R3");
        // R2/R4: long unbroken sweep of mixed values
        for (int i = 0; i < 4096; i++) begin
            step((i * 7 + (i / 16) * 3 + (i / 256) * 5) % 16, 1, "R2_R4");
        end

        // R5/R6: scattered gaps
        for (int i = 0; i < 600; i++) begin
            bit v;
            v = ((i % 3) != 1) && ((i % 7) != 4);
            step((i * 11 + 5) % 16, v, v ? "R6" : "R5");
        end

        // R8: top of range, then all zeros
        for (int i = 0; i < 6; i++) step(15, 1, "R8");
        check("R8 peak", int'(out_sum), 105);
        for (int i = 0; i < 5; i++) step(0, 1, "R8_zero");

        // R7: reset mid-stream, stale samples must not leak
        for (int i = 0; i < 4; i++) step(9 + i, 1, "R7_pre");
        do_reset("R7");
        step(2, 1, "R7");
        step(0, 0, "R7");
        step(4, 1, "R7");
        step(6, 1, "R7");
        step(8, 1, "R7");
        for (int i = 0; i < 8; i++) step(i, 1, "R7_run");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule